// File: doc/BRIEF.md
# Background Tile Column Fetcher and Layer Mixer

This block turns one request (a column number and a line number) into eight palette indices for that background column. It adds the scroll settings to the column and line to find the name-table entry, then reads the 16-bit tile entry from byte-wide video memory, low byte first. It reads the four plane bytes of the selected pattern row, applying vertical and horizontal flip. Each pixel is then merged with the matching pixel of the sprite line buffer and with the backdrop colour, and the result is a 5-bit palette index.

Requests arrive on a valid/ready input and pixels leave on a valid/ready output. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The scroll, lock, mask, shift, backdrop and display settings are sampled on that edge. The block then holds `req_ready` low until all eight pixels of the column have been accepted. A pixel is accepted on an edge where `pix_valid` and `pix_ready` are both high. While `pix_ready` is low, the block holds the same pixel. Video memory answers a read one cycle after `mem_rd`. The line buffer answers its address within the same cycle.

Top module: `bg_column_mixer`

## Requirements
- R1: `req_ready` is high exactly when idle. After out of reset the block is idle with `pix_valid` and `mem_rd` low. Each accepted request yields exactly eight pixels, leftmost first, after which the block is idle again.
- R2: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_index` does not change.
- R3: The vertical position is line + Y-scroll. If that sum exceeds 223, 224 is subtracted. When the vertical lock is set, Y-scroll is not added for columns 24 to 31.
- R4: The first two memory reads of a column are at N and N+1, where N = base × 2048 + (vertical position / 8) × 64 + 2 × (((column × 8 + X-scroll) mod 256) / 8). The byte at N is the entry's low byte and the byte at N+1 is its high byte.
- R5: When the horizontal lock is set, X-scroll is treated as 0 for lines 0 to 15.
- R6: Tile entry fields are: bits 8:0 tile number, bit 9 horizontal flip, bit 10 vertical flip, bit 11 palette, bit 12 priority. Four plane bytes are read at tile × 32 + row × 4 + k, for k = 0..3, and plane byte k supplies bit k of each pixel colour. The leftmost pixel takes bit 7 of each plane byte; horizontal flip makes it take bit 0 instead.
- R7: The row is the vertical position mod 8. With vertical flip, row r becomes 7 − r.
- R8: Each pixel is resolved in this order: {palette, colour} if priority is set and the colour is non-zero; else {1, sprite} if the sprite pixel is non-zero; else {palette, colour} if the colour is non-zero; else {1, backdrop}.
- R9: The sprite pixel for column pixel i is read at line-buffer address column × 8 + i. When sprite shift is set, the address is column × 8 + i + 8.
- R10: With the column-0 mask set, column 0 gives eight {1, backdrop} pixels and issues no memory read. Other columns are unaffected.
- R11: The display is active only for lines below 192 with both display enable and mode select high. A column requested while the display is inactive gives eight {1, backdrop} pixels and issues no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disp_en | input | 1 | Display enable |
| cfg_mode_sel | input | 1 | Tile mode select |
| cfg_name_base | input | 3 | Name table base, in 2 KiB units |
| cfg_xscroll | input | 8 | Horizontal scroll |
| cfg_yscroll | input | 8 | Vertical scroll |
| cfg_hlock | input | 1 | No horizontal scroll on lines 0-15 |
| cfg_vlock | input | 1 | No vertical scroll on columns 24-31 |
| cfg_col0_mask | input | 1 | Show backdrop in column 0 |
| cfg_spr_shift | input | 1 | Read sprite pixels 8 positions further on |
| cfg_backdrop | input | 4 | Backdrop colour in the upper palette |
| req_valid | input | 1 | Column request valid |
| req_ready | output | 1 | Ready for a column request |
| req_col | input | 5 | Column number |
| req_line | input | 8 | Line number |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 14 | Memory byte address |
| mem_data | input | 8 | Read data, one cycle after strobe |
| lb_addr | output | 9 | Sprite line buffer address |
| lb_data | input | 4 | Sprite pixel, 0 = transparent |
| pix_valid | output | 1 | Pixel valid |
| pix_ready | input | 1 | Pixel accepted |
| pix_index | output | 5 | Palette index |

## Verification
The hardest case to reach from the ports is a tile entry with a chosen combination of flip, palette and priority bits, sitting at a name-table address that depends on the scroll arithmetic. The bench's memory model returns a computed byte pattern everywhere except at one programmable pair of addresses. Each flip and priority scenario first computes the name address of the target column from the requirements, then places its chosen entry there. Wrap at 224 lines and the lock boundaries are reached by choosing scroll values and column and line numbers right at each edge. Pixel back-pressure is applied with a repeating stall pattern on `pix_ready`.

// File: rtl/bg_mix_pkg.sv
package bg_mix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_PIX  = 2'd3
  } mix_state_t;

  // 16-bit name-table entry layout
  typedef struct packed {
    logic [2:0] spare;
    logic       prio;
    logic       pal;
    logic       vflip;
    logic       hflip;
    logic [8:0] tile;
  } tile_entry_t;

endpackage

// File: rtl/bg_addr_gen.sv
module bg_addr_gen #(
  parameter int COL_W        = 5,
  parameter int LINE_W       = 8,
  parameter int ADDR_W       = 14,
  parameter int ACTIVE_LINES = 192,
  parameter int WRAP_LINES   = 224,
  parameter int LOCK_COL     = 24,
  parameter int HLOCK_LINES  = 16
) (
  input  logic [COL_W-1:0]  col,
  input  logic [LINE_W-1:0] line,
  input  logic              disp_en,
  input  logic              mode_sel,
  input  logic [2:0]        base,
  input  logic [COL_W+2:0]  xscroll,
  input  logic [LINE_W-1:0] yscroll,
  input  logic              hlock,
  input  logic              vlock,
  output logic [ADDR_W-1:0] name_addr,
  output logic [2:0]        fine_row,
  output logic [LINE_W:0]   vpos,
  output logic              active
);
  localparam int XS_W       = COL_W + 3;
  localparam int BASE_SHIFT = ADDR_W - 3;

  logic [LINE_W-1:0] ys_eff;
  logic [XS_W-1:0]   xs_eff;
  logic [LINE_W:0]   vsum;
  logic [XS_W-1:0]   xsum;

  always_comb begin
    ys_eff = (vlock && col >= COL_W'(LOCK_COL)) ? '0 : yscroll;
    xs_eff = (hlock && line < LINE_W'(HLOCK_LINES)) ? '0 : xscroll;
    vsum   = {1'b0, line} + {1'b0, ys_eff};
    vpos   = (vsum > (LINE_W+1)'(WRAP_LINES - 1)) ? vsum - (LINE_W+1)'(WRAP_LINES) : vsum;
    xsum   = {col, 3'b000} + xs_eff;
    fine_row  = vpos[2:0];
    name_addr = (ADDR_W'(base) << BASE_SHIFT)
              + (ADDR_W'(vpos[LINE_W-1:3]) << 6)
              + (ADDR_W'(xsum[XS_W-1:3]) << 1);
    active = disp_en && mode_sel && (line < LINE_W'(ACTIVE_LINES));
  end
endmodule

// File: rtl/bg_pixel_mux.sv
module bg_pixel_mux (
  input  logic       blank,
  input  logic [3:0] bg_col,
  input  logic       bg_pal,
  input  logic       bg_prio,
  input  logic [3:0] spr_col,
  input  logic [3:0] backdrop,
  output logic [4:0] index
);
  always_comb begin
    if (blank)                         index = {1'b1, backdrop};
    else if (bg_prio && bg_col != '0)  index = {bg_pal, bg_col};
    else if (spr_col != '0)            index = {1'b1, spr_col};
    else if (bg_col != '0)             index = {bg_pal, bg_col};
    else                               index = {1'b1, backdrop};
  end
endmodule

// File: rtl/bg_column_mixer.sv
module bg_column_mixer
  import bg_mix_pkg::*;
#(
  parameter int COL_W        = 5,
  parameter int LINE_W       = 8,
  parameter int ADDR_W       = 14,
  parameter int LB_AW        = 9,
  parameter int ACTIVE_LINES = 192,
  parameter int WRAP_LINES   = 224,
  parameter int LOCK_COL     = 24,
  parameter int HLOCK_LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_disp_en,
  input  logic              cfg_mode_sel,
  input  logic [2:0]        cfg_name_base,
  input  logic [COL_W+2:0]  cfg_xscroll,
  input  logic [LINE_W-1:0] cfg_yscroll,
  input  logic              cfg_hlock,
  input  logic              cfg_vlock,
  input  logic              cfg_col0_mask,
  input  logic              cfg_spr_shift,
  input  logic [3:0]        cfg_backdrop,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LINE_W-1:0] req_line,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic [LB_AW-1:0]  lb_addr,
  input  logic [3:0]        lb_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [4:0]        pix_index
);
  localparam int PLANES = 4;
  localparam int NREADS = 2 + PLANES;
  localparam int PIXELS = 8;

  mix_state_t        state_q;
  logic [2:0]        idx_q, pcnt_q;
  logic [COL_W-1:0]  col_q;
  logic [ADDR_W-1:0] name_q;
  logic [2:0]        frow_q;
  logic              blank_q, shift_q;
  logic [3:0]        bd_q;
  tile_entry_t       entry_q;
  logic [7:0]        plane_q [PLANES];

  logic [ADDR_W-1:0] ag_name;
  logic [2:0]        ag_frow;
  logic [LINE_W:0]   ag_vpos;
  logic              ag_active;

  bg_addr_gen #(
    .COL_W(COL_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .ACTIVE_LINES(ACTIVE_LINES),
    .WRAP_LINES(WRAP_LINES), .LOCK_COL(LOCK_COL), .HLOCK_LINES(HLOCK_LINES)
  ) u_addr (
    .col(req_col), .line(req_line), .disp_en(cfg_disp_en), .mode_sel(cfg_mode_sel),
    .base(cfg_name_base), .xscroll(cfg_xscroll), .yscroll(cfg_yscroll),
    .hlock(cfg_hlock), .vlock(cfg_vlock), .name_addr(ag_name), .fine_row(ag_frow),
    .vpos(ag_vpos), .active(ag_active)
  );

  logic blank_in;
  assign blank_in  = !ag_active || (req_col == '0 && cfg_col0_mask);
  assign req_ready = (state_q == ST_IDLE);

  // read address sequencing: entry low, entry high, then four plane bytes
  logic [2:0]        row_sel;
  logic [ADDR_W-1:0] pat_addr, rd_addr;
  logic [1:0]        pl_sel;
  assign row_sel  = entry_q.vflip ? ~frow_q : frow_q;
  assign pat_addr = (ADDR_W'(entry_q.tile) << 5) + (ADDR_W'(row_sel) << 2);
  assign pl_sel   = 2'(idx_q - 3'd2);

  always_comb begin
    case (idx_q)
      3'd0:    rd_addr = name_q;
      3'd1:    rd_addr = name_q + ADDR_W'(1);
      default: rd_addr = pat_addr + ADDR_W'(pl_sel);
    endcase
  end
  assign mem_rd   = (state_q == ST_ADDR);
  assign mem_addr = rd_addr;

  // planar to per-pixel colour
  logic [2:0] bit_sel;
  logic [3:0] bg_col;
  assign bit_sel = entry_q.hflip ? pcnt_q : 3'd7 - pcnt_q;
  for (genvar k = 0; k < PLANES; k++) begin : g_plane
    assign bg_col[k] = plane_q[k][bit_sel];
  end

  assign lb_addr = (LB_AW'(col_q) << 3) + LB_AW'(pcnt_q) + (shift_q ? LB_AW'(PIXELS) : '0);

  bg_pixel_mux u_mux (
    .blank(blank_q), .bg_col(bg_col), .bg_pal(entry_q.pal), .bg_prio(entry_q.prio),
    .spr_col(lb_data), .backdrop(bd_q), .index(pix_index)
  );
  assign pix_valid = (state_q == ST_PIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pcnt_q  <= '0;
      col_q   <= '0;
      name_q  <= '0;
      frow_q  <= '0;
      blank_q <= 1'b0;
      shift_q <= 1'b0;
      bd_q    <= '0;
      entry_q <= '0;
      for (int k = 0; k < PLANES; k++) plane_q[k] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          col_q   <= req_col;
          name_q  <= ag_name;
          frow_q  <= ag_frow;
          blank_q <= blank_in;
          shift_q <= cfg_spr_shift;
          bd_q    <= cfg_backdrop;
          idx_q   <= '0;
          pcnt_q  <= '0;
          state_q <= blank_in ? ST_PIX : ST_ADDR;
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          case (idx_q)
            3'd0:    entry_q[7:0]  <= mem_data;
            3'd1:    entry_q[15:8] <= mem_data;
            default: plane_q[pl_sel] <= mem_data;
          endcase
          if (idx_q == 3'(NREADS - 1)) state_q <= ST_PIX;
          else begin
            idx_q   <= idx_q + 3'd1;
            state_q <= ST_ADDR;
          end
        end
        ST_PIX: if (pix_ready) begin
          pcnt_q <= pcnt_q + 3'd1;
          if (pcnt_q == 3'(PIXELS - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a stalled pixel is held unchanged
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_index));

  // R1: accepting requests only while neither reading nor emitting
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !pix_valid && !mem_rd);

  // R3: wrapped vertical position stays inside the 224-line map
  a_r3_vpos_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
    ag_vpos < (LINE_W+1)'(WRAP_LINES));

  // R11: an inactive-display request goes straight to pixel output
  a_r11_inactive_direct: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !ag_active |=> pix_valid && !mem_rd);

  // R10: a masked column 0 skips the memory reads
  a_r10_col0_direct: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_col == '0 && cfg_col0_mask |=> pix_valid && !mem_rd);

endmodule

// File: tb/test_bg_column_mixer.sv
module test_bg_column_mixer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        cfg_disp_en, cfg_mode_sel, cfg_hlock, cfg_vlock, cfg_col0_mask, cfg_spr_shift;
  logic [2:0]  cfg_name_base;
  logic [7:0]  cfg_xscroll, cfg_yscroll;
  logic [3:0]  cfg_backdrop;
  logic        req_valid, req_ready;
  logic [4:0]  req_col;
  logic [7:0]  req_line;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [7:0]  mem_data;
  logic [8:0]  lb_addr;
  logic [3:0]  lb_data;
  logic        pix_valid, pix_ready;
  logic [4:0]  pix_index;

  bg_column_mixer i_bg_column_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_disp_en(cfg_disp_en), .cfg_mode_sel(cfg_mode_sel),
    .cfg_name_base(cfg_name_base), .cfg_xscroll(cfg_xscroll), .cfg_yscroll(cfg_yscroll),
    .cfg_hlock(cfg_hlock), .cfg_vlock(cfg_vlock), .cfg_col0_mask(cfg_col0_mask),
    .cfg_spr_shift(cfg_spr_shift), .cfg_backdrop(cfg_backdrop), .req_valid(req_valid),
    .req_ready(req_ready), .req_col(req_col), .req_line(req_line), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .lb_addr(lb_addr), .lb_data(lb_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index)
  );

  int checks = 0;
  int fails  = 0;

  // memory model: computed bytes plus one programmable 16-bit entry
  logic        ov_en = 1'b0;
  logic [13:0] ov_addr = '0;
  logic [15:0] ov_val = '0;
  int          lb_mode = 0;
  int          rd_total = 0;
  logic [13:0] rd_log [8];

  function automatic logic [7:0] mem_f(input logic [13:0] a);
    if (ov_en && a == ov_addr) return ov_val[7:0];
    if (ov_en && a == ov_addr + 14'd1) return ov_val[15:8];
    return 8'((int'(a) * 29 + (int'(a) >> 6) * 13 + 11) & 255);
  endfunction

  function automatic logic [3:0] lb_f(input int a);
    if (lb_mode == 0) return 4'h0;
    if (lb_mode == 2) return 4'hF;
    if (a % 3 == 0) return 4'h0;
    return 4'((a * 7 + 3) & 15);
  endfunction

  initial mem_data = '0;
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= mem_f(mem_addr);
      rd_log[rd_total % 8] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  always_comb begin
    if (lb_mode == 0)           lb_data = 4'h0;
    else if (lb_mode == 2)      lb_data = 4'hF;
    else if (lb_addr % 3 == 0)  lb_data = 4'h0;
    else                        lb_data = 4'(lb_addr * 7 + 3);
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int vpos_of(input int col, input int line);
    int v;
    v = line + ((cfg_vlock && col >= 24) ? 0 : int'(cfg_yscroll));
    if (v > 223) v -= 224;
    return v;
  endfunction

  function automatic logic [13:0] calc_na(input int col, input int line);
    int xs, ci;
    xs = (cfg_hlock && line < 16) ? 0 : int'(cfg_xscroll);
    ci = ((col * 8 + xs) % 256) / 8;
    return 14'(int'(cfg_name_base) * 2048 + (vpos_of(col, line) / 8) * 64 + ci * 2);
  endfunction

  // one column: compute expected values, request, collect, compare
  task automatic run_col(input int col, input int line, input string tag, input bit stall);
    logic [4:0]  expv [8];
    logic [4:0]  got  [8];
    logic [15:0] ent;
    logic [7:0]  pb [4];
    logic [13:0] na;
    int row, pa, start, n, cyc, bp, sp;
    bit blank, prev_stall;
    logic [4:0] prev_idx, c;
    blank = !(line < 192 && cfg_disp_en && cfg_mode_sel) || (col == 0 && cfg_col0_mask);
    na  = calc_na(col, line);
    ent = {mem_f(na + 14'd1), mem_f(na)};
    row = vpos_of(col, line) % 8;
    if (ent[10]) row = 7 - row;
    pa = int'(ent[8:0]) * 32 + row * 4;
    for (int k = 0; k < 4; k++) pb[k] = mem_f(14'(pa + k));
    for (int i = 0; i < 8; i++) begin
      bp = ent[9] ? i : 7 - i;
      c  = {1'b0, pb[3][bp], pb[2][bp], pb[1][bp], pb[0][bp]};
      sp = col * 8 + i + (cfg_spr_shift ? 8 : 0);
      if (blank)                         expv[i] = {1'b1, cfg_backdrop};
      else if (ent[12] && c[3:0] != 0)   expv[i] = {ent[11], c[3:0]};
      else if (lb_f(sp) != 0)            expv[i] = {1'b1, lb_f(sp)};
      else if (c[3:0] != 0)              expv[i] = {ent[11], c[3:0]};
      else                               expv[i] = {1'b1, cfg_backdrop};
    end
    start = rd_total;
    @(negedge clk);
    chk("R1", 32'(req_ready), 32'd1, "ready before request");
    req_valid = 1'b1;
    req_col   = 5'(col);
    req_line  = 8'(line);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; cyc = 0; prev_stall = 1'b0; prev_idx = '0;
    while (n < 8 && cyc < 200) begin
      pix_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (prev_stall) begin
        chk("R2", 32'(pix_valid), 32'd1, "valid held in stall");
        chk("R2", 32'(pix_index), 32'(prev_idx), "index held in stall");
      end
      if (pix_valid && pix_ready) begin
        got[n] = pix_index;
        n++;
      end
      prev_stall = pix_valid && !pix_ready;
      prev_idx   = pix_index;
      cyc++;
      @(negedge clk);
    end
    pix_ready = 1'b1;
    chk("R1", 32'(n), 32'd8, "pixels per column");
    chk("R1", 32'(req_ready), 32'd1, "idle after column");
    for (int i = 0; i < n; i++) chk(tag, 32'(got[i]), 32'(expv[i]), $sformatf("pixel %0d", i));
    if (blank) begin
      chk(tag, 32'(rd_total - start), 32'd0, "reads for backdrop column");
    end else begin
      chk(tag, 32'(rd_total - start), 32'd6, "reads per column");
      chk("R4", 32'(rd_log[start % 8]), 32'(na), "entry address");
      chk("R4", 32'(rd_log[(start + 1) % 8]), 32'(na + 14'd1), "entry high address");
    end
  endtask

  task automatic set_defaults();
    cfg_disp_en = 1'b1; cfg_mode_sel = 1'b1; cfg_name_base = 3'd5;
    cfg_xscroll = '0; cfg_yscroll = '0; cfg_hlock = 1'b0; cfg_vlock = 1'b0;
    cfg_col0_mask = 1'b0; cfg_spr_shift = 1'b0; cfg_backdrop = 4'hA;
    lb_mode = 0; ov_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_col = '0; req_line = '0; pix_ready = 1'b1;
    set_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(req_ready), 32'd1, "reset ready");
    chk("R1", 32'(pix_valid), 32'd0, "reset pix_valid");
    chk("R1", 32'(mem_rd), 32'd0, "reset mem_rd");
  endtask

  task automatic t_basic();
    set_defaults();
    run_col(1, 0, "R6", 1'b0);
    run_col(7, 37, "R6", 1'b0);
    run_col(20, 100, "R4", 1'b0);
    cfg_name_base = 3'd7;
    run_col(31, 191, "R4", 1'b0);
  endtask

  task automatic t_scroll();
    set_defaults();
    cfg_yscroll = 8'd200;
    run_col(4, 50, "R3", 1'b0);   // 250 wraps to 26
    run_col(4, 23, "R3", 1'b0);   // 223, no wrap
    run_col(4, 24, "R3", 1'b0);   // 224 wraps to 0
    cfg_vlock = 1'b1;
    run_col(23, 50, "R3", 1'b0);
    run_col(24, 50, "R3", 1'b0);
    cfg_xscroll = 8'd13; cfg_hlock = 1'b1;
    run_col(9, 15, "R5", 1'b0);
    run_col(9, 16, "R5", 1'b0);
    cfg_hlock = 1'b0;
    run_col(31, 15, "R5", 1'b0);
  endtask

  task automatic t_flip();
    set_defaults();
    ov_en = 1'b1;
    ov_addr = calc_na(3, 9);
    ov_val = 16'h0400 | 16'h01A5;
    run_col(3, 9, "R7", 1'b0);
    ov_val = 16'h0200 | 16'h01A5;
    run_col(3, 9, "R6", 1'b0);
    ov_val = 16'h0600 | 16'h0033;
    run_col(3, 9, "R7", 1'b0);
  endtask

  task automatic t_priority();
    set_defaults();
    ov_en = 1'b1;
    ov_addr = calc_na(6, 40);
    lb_mode = 1;
    ov_val = 16'h1800 | 16'h0077;
    run_col(6, 40, "R8", 1'b0);
    ov_val = 16'h0800 | 16'h0077;
    run_col(6, 40, "R8", 1'b0);
    lb_mode = 2;
    ov_val = 16'h1000 | 16'h0012;
    run_col(6, 40, "R8", 1'b0);
    ov_val = 16'h0012;
    run_col(6, 40, "R8", 1'b0);
  endtask

  task automatic t_shift();
    set_defaults();
    lb_mode = 1;
    run_col(5, 60, "R9", 1'b0);
    cfg_spr_shift = 1'b1;
    run_col(5, 60, "R9", 1'b0);
    run_col(31, 60, "R9", 1'b0);
  endtask

  task automatic t_col0();
    set_defaults();
    cfg_col0_mask = 1'b1;
    lb_mode = 2;
    run_col(0, 12, "R10", 1'b0);
    run_col(1, 12, "R10", 1'b0);
    cfg_col0_mask = 1'b0;
    run_col(0, 12, "R10", 1'b0);
  endtask

  task automatic t_inactive();
    set_defaults();
    run_col(8, 192, "R11", 1'b0);
    run_col(8, 191, "R11", 1'b0);
    cfg_disp_en = 1'b0;
    run_col(8, 5, "R11", 1'b0);
    cfg_disp_en = 1'b1; cfg_mode_sel = 1'b0;
    run_col(8, 5, "R11", 1'b0);
  endtask

  task automatic t_backpressure();
    set_defaults();
    lb_mode = 1;
    run_col(12, 70, "R2", 1'b1);
    run_col(2, 200, "R2", 1'b1);
    cfg_yscroll = 8'd99;
    run_col(27, 150, "R2", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_scroll();
    t_flip();
    t_priority();
    t_shift();
    t_col0();
    t_inactive();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule